// File: doc/BRIEF.md
# Shared Active-Low Control Line Combiner

This block resolves four shared active-low control lines (test, stop, storage reset and user reset) that are wired-OR across up to fifteen expansion cards and one host. Every participant is a separate source with its own assert bit, so the combiner holds one assertion mask per line, with one bit per source. One update strobe carries a line number, a source index and the level that source now drives.

An update that changes the recorded state of its source is passed on to the other participants. The originator is never told about its own change. Each other listener hears about it only when no further source is holding the line, so the level it sees is the line as seen from its own position. Each listener gets a one-cycle event pulse and a held level. Notification runs through the card slots in order and stops at the first slot marked empty.

Top module: `ctlLineCombiner`

## Requirements
- R1: After reset every assertion mask is clear, every host and card level reads 1 (deasserted) and no event pulse is high.
- R2: Line codes are 0 test, 1 stop, 2 storage reset and 3 user reset. Source indices 0 to 14 are cards and 15 is the host. Driving 0 asserts the source's bit and driving 1 releases it. Each line has its own mask.
- R3: An update whose level equals the recorded state of that source on that line is dropped and produces no event.
- R4: The host is notified of a card's change when no card other than the originator asserts the line. The host's own bit does not block this. The host is never notified of its own updates.
- R5: A card other than the originator is notified only when no source other than the originator (the host included) asserts the line. The originator itself is never notified.
- R6: On the user-reset line (code 3), updates from source 15 are ignored and leave the mask untouched.
- R7: Only cards in slots below the first clear bit of slotFilled are notified. A filled slot above a gap receives nothing.
- R8: Event pulses and level changes appear in the cycle after the update strobe and last one cycle. A cycle with no strobe yields no event.
- R9: Whenever a listener receives an event, its held level becomes the level carried by that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| updValid | input | 1 | Update strobe |
| updLine | input | 2 | Line code of the update |
| updSrc | input | 4 | Source index (15 = host) |
| updLevel | input | 1 | Level now driven by the source |
| slotFilled | input | 15 | Card slot occupancy |
| hostEvt | output | 4 | Per-line host change pulse |
| hostLevel | output | 4 | Per-line level seen by the host |
| cardEvt | output | 60 | Change pulse, bit line*15+card |
| cardLevel | output | 60 | Level seen by each card, bit line*15+card |

## Verification
Every result is registered once. An update driven before a rising edge shows its event pulses and new levels right after that edge, and the pulses are gone one edge later. The bench drives inputs on the falling edge, holds the strobe for one cycle and samples all outputs on the next falling edge. An extra idle sample confirms the pulses clear. Held levels are tracked in the bench only from the events the table expects.

// File: rtl/ctlLinePkg.sv
package ctlLinePkg;
  localparam int NUM_LINES = 4;
  localparam int NUM_CARDS = 15;
  localparam int NUM_SRC   = NUM_CARDS + 1;
  localparam int SRC_W     = $clog2(NUM_SRC);
  localparam int LINE_W    = $clog2(NUM_LINES);
  localparam int HOST_IDX  = NUM_CARDS;
  localparam int USER_LINE = 3;

  typedef struct packed {
    logic                 maskWr;
    logic [LINE_W-1:0]    lineSel;
    logic [SRC_W-1:0]     srcSel;
    logic                 level;
    logic                 hostNotify;
    logic [NUM_CARDS-1:0] cardNotify;
  } strobeT;
endpackage

// File: rtl/ctlLineCtrl.sv
module ctlLineCtrl
  import ctlLinePkg::*;
(
  input  logic                 updValid,
  input  logic [LINE_W-1:0]    updLine,
  input  logic [SRC_W-1:0]     updSrc,
  input  logic                 updLevel,
  input  logic [NUM_CARDS-1:0] slotFilled,
  input  logic [NUM_SRC-1:0]   curMask,
  output strobeT               strobes
);
  logic                 changed;
  logic                 ignored;
  logic                 take;
  logic [NUM_SRC-1:0]   otherMask;
  logic [NUM_SRC-1:0]   hostBit;
  logic [NUM_CARDS-1:0] chainOk;

  assign hostBit   = NUM_SRC'(1) << HOST_IDX;
  assign changed   = (updLevel == curMask[updSrc]);
  assign ignored   = (updLine == LINE_W'(USER_LINE)) && (updSrc == SRC_W'(HOST_IDX));
  assign take      = updValid && changed && !ignored;
  assign otherMask = curMask & ~(NUM_SRC'(1) << updSrc);

  genvar c;
  generate
    for (c = 0; c < NUM_CARDS; c++) begin : gChain
      if (c == 0) begin : gFirst
        assign chainOk[c] = slotFilled[c];
      end else begin : gRest
        assign chainOk[c] = slotFilled[c] && chainOk[c-1];
      end
      assign strobes.cardNotify[c] = take && chainOk[c] && (otherMask == '0)
                                     && (updSrc != SRC_W'(c));
    end
  endgenerate

  assign strobes.maskWr     = take;
  assign strobes.lineSel    = updLine;
  assign strobes.srcSel     = updSrc;
  assign strobes.level      = updLevel;
  assign strobes.hostNotify = take && (updSrc != SRC_W'(HOST_IDX))
                              && ((otherMask & ~hostBit) == '0);
endmodule

// File: rtl/ctlLineData.sv
module ctlLineData
  import ctlLinePkg::*;
(
  input  logic                                clk,
  input  logic                                rstN,
  input  strobeT                              strobes,
  input  logic [LINE_W-1:0]                   rdLine,
  output logic [NUM_SRC-1:0]                  curMask,
  output logic [NUM_LINES-1:0]                hostEvt,
  output logic [NUM_LINES-1:0]                hostLevel,
  output logic [NUM_LINES-1:0][NUM_CARDS-1:0] cardEvt,
  output logic [NUM_LINES-1:0][NUM_CARDS-1:0] cardLevel
);
  logic [NUM_LINES-1:0][NUM_SRC-1:0] masks;

  assign curMask = masks[rdLine];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      masks     <= '0;
      hostEvt   <= '0;
      hostLevel <= '1;
      cardEvt   <= '0;
      cardLevel <= '1;
    end else begin
      hostEvt <= '0;
      cardEvt <= '0;
      if (strobes.maskWr) begin
        masks[strobes.lineSel][strobes.srcSel] <= ~strobes.level;
        if (strobes.hostNotify) begin
          hostEvt[strobes.lineSel]   <= 1'b1;
          hostLevel[strobes.lineSel] <= strobes.level;
        end
        cardEvt[strobes.lineSel] <= strobes.cardNotify;
        for (int c = 0; c < NUM_CARDS; c++) begin
          if (strobes.cardNotify[c]) cardLevel[strobes.lineSel][c] <= strobes.level;
        end
      end
    end
  end
endmodule

// File: rtl/ctlLineCombiner.sv
module ctlLineCombiner
  import ctlLinePkg::*;
(
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           updValid,
  input  logic [LINE_W-1:0]              updLine,
  input  logic [SRC_W-1:0]               updSrc,
  input  logic                           updLevel,
  input  logic [NUM_CARDS-1:0]           slotFilled,
  output logic [NUM_LINES-1:0]           hostEvt,
  output logic [NUM_LINES-1:0]           hostLevel,
  output logic [NUM_LINES*NUM_CARDS-1:0] cardEvt,
  output logic [NUM_LINES*NUM_CARDS-1:0] cardLevel
);
  strobeT                              strobes;
  logic [NUM_SRC-1:0]                  curMask;
  logic [NUM_LINES-1:0][NUM_CARDS-1:0] cardEvtArr;
  logic [NUM_LINES-1:0][NUM_CARDS-1:0] cardLevelArr;

  ctlLineCtrl uCtrl (
    .updValid  (updValid),
    .updLine   (updLine),
    .updSrc    (updSrc),
    .updLevel  (updLevel),
    .slotFilled(slotFilled),
    .curMask   (curMask),
    .strobes   (strobes)
  );

  ctlLineData uData (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .rdLine   (updLine),
    .curMask  (curMask),
    .hostEvt  (hostEvt),
    .hostLevel(hostLevel),
    .cardEvt  (cardEvtArr),
    .cardLevel(cardLevelArr)
  );

  assign cardEvt   = cardEvtArr;
  assign cardLevel = cardLevelArr;
endmodule

// File: rtl/ctlLineChecker.sv
module ctlLineChecker
  import ctlLinePkg::*;
(
  input logic                           clk,
  input logic                           rstN,
  input logic                           updValid,
  input logic [LINE_W-1:0]              updLine,
  input logic [SRC_W-1:0]               updSrc,
  input logic                           updLevel,
  input logic [NUM_CARDS-1:0]           slotFilled,
  input logic [NUM_LINES-1:0]           hostEvt,
  input logic [NUM_LINES-1:0]           hostLevel,
  input logic [NUM_LINES*NUM_CARDS-1:0] cardEvt,
  input logic [NUM_LINES*NUM_CARDS-1:0] cardLevel
);
  logic [NUM_CARDS-1:0] reach;
  always_comb begin
    logic run;
    run = 1'b1;
    for (int c = 0; c < NUM_CARDS; c++) begin
      run      = run && slotFilled[c];
      reach[c] = run;
    end
  end

  // R8: an idle cycle produces no event
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    !updValid |=> (hostEvt == '0 && cardEvt == '0));

  // R4: the host never hears its own change
  p_host_self_r4: assert property (@(posedge clk) disable iff (!rstN)
    (updValid && updSrc == SRC_W'(HOST_IDX)) |=> (hostEvt == '0));

  // R6: a host update on the user-reset line yields nothing
  p_user_host_r6: assert property (@(posedge clk) disable iff (!rstN)
    (updValid && updSrc == SRC_W'(HOST_IDX) && updLine == LINE_W'(USER_LINE))
    |=> (hostEvt == '0 && cardEvt == '0));

  genvar l, c;
  generate
    for (l = 0; l < NUM_LINES; l++) begin : gLine
      // R9: a host event carries the driven level
      p_host_level_r9: assert property (@(posedge clk) disable iff (!rstN)
        hostEvt[l] |-> (hostLevel[l] == $past(updLevel)));
      // R7: no card beyond the first empty slot hears anything
      p_slot_gap_r7: assert property (@(posedge clk) disable iff (!rstN)
        (cardEvt[l*NUM_CARDS +: NUM_CARDS] & ~$past(reach)) == '0);
    end
    for (c = 0; c < NUM_CARDS; c++) begin : gCard
      // R5: the originator is never notified
      p_origin_quiet_r5: assert property (@(posedge clk) disable iff (!rstN)
        (updValid && updSrc == SRC_W'(c)) |=>
        (cardEvt[0*NUM_CARDS+c] == 1'b0 && cardEvt[1*NUM_CARDS+c] == 1'b0 &&
         cardEvt[2*NUM_CARDS+c] == 1'b0 && cardEvt[3*NUM_CARDS+c] == 1'b0));
    end
  endgenerate
endmodule

bind ctlLineCombiner ctlLineChecker uChk (
  .clk(clk), .rstN(rstN), .updValid(updValid), .updLine(updLine),
  .updSrc(updSrc), .updLevel(updLevel), .slotFilled(slotFilled),
  .hostEvt(hostEvt), .hostLevel(hostLevel), .cardEvt(cardEvt),
  .cardLevel(cardLevel)
);

// File: tb/ctlLineCombiner_test.sv
module ctlLineCombiner_test;
  localparam int NC = 15;
  localparam int NL = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          updValid = 1'b0;
  logic [1:0]    updLine = '0;
  logic [3:0]    updSrc = '0;
  logic          updLevel = 1'b1;
  logic [NC-1:0] slotFilled = 15'h005F;
  logic [NL-1:0] hostEvt, hostLevel;
  logic [NL*NC-1:0] cardEvt, cardLevel;

  int checks = 0;
  int fails = 0;

  logic [NL-1:0]    expHostL;
  logic [NL*NC-1:0] expCardL;

  always #5 clk = ~clk;

  ctlLineCombiner uut (
    .clk(clk), .rstN(rstN), .updValid(updValid), .updLine(updLine),
    .updSrc(updSrc), .updLevel(updLevel), .slotFilled(slotFilled),
    .hostEvt(hostEvt), .hostLevel(hostLevel), .cardEvt(cardEvt),
    .cardLevel(cardLevel)
  );

  // {line, src, level, hostEvt, cardEvt}; slots 0-4 and 6 filled, 5 empty
  localparam int NV = 18;
  localparam logic [22:0] VEC [NV] = '{
    {2'd0, 4'd1,  1'b0, 1'b1, 15'h001D},  // R4 R5 first assert
    {2'd0, 4'd1,  1'b0, 1'b0, 15'h0000},  // R3 repeat
    {2'd0, 4'd3,  1'b0, 1'b0, 15'h0000},  // R4 R5 second holder
    {2'd0, 4'd1,  1'b1, 1'b0, 15'h0000},  // R5 still held
    {2'd0, 4'd3,  1'b1, 1'b1, 15'h0017},  // R4 R5 last release
    {2'd0, 4'd15, 1'b0, 1'b0, 15'h001F},  // R4 host origin
    {2'd0, 4'd2,  1'b0, 1'b1, 15'h0000},  // R4 host bit ignored, R5 host blocks
    {2'd0, 4'd15, 1'b1, 1'b0, 15'h0000},  // R5 card holds
    {2'd0, 4'd2,  1'b1, 1'b1, 15'h001B},  // R4 R5 release
    {2'd3, 4'd15, 1'b0, 1'b0, 15'h0000},  // R6 host on user reset
    {2'd3, 4'd0,  1'b0, 1'b1, 15'h001E},  // R6 mask untouched
    {2'd3, 4'd4,  1'b0, 1'b0, 15'h0000},  // R5
    {2'd3, 4'd0,  1'b1, 1'b0, 15'h0000},  // R5
    {2'd3, 4'd4,  1'b1, 1'b1, 15'h000F},  // R4 R5
    {2'd1, 4'd6,  1'b0, 1'b1, 15'h001F},  // R7 gap at slot 5
    {2'd1, 4'd6,  1'b1, 1'b1, 15'h001F},  // R7
    {2'd2, 4'd0,  1'b0, 1'b1, 15'h001E},  // R2 storage reset line
    {2'd0, 4'd1,  1'b0, 1'b1, 15'h001D}   // R2 lines independent
  };

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic [1:0] ln, input logic [3:0] src, input logic lvl,
                       input logic hEvt, input logic [NC-1:0] cEvt, input string req);
    logic [NL*NC-1:0] expEvt;
    logic [NL-1:0]    expH;
    @(negedge clk);
    updValid = 1'b1; updLine = ln; updSrc = src; updLevel = lvl;
    @(negedge clk);
    updValid = 1'b0;
    expEvt = '0;
    expEvt[ln*NC +: NC] = cEvt;
    expH = '0;
    expH[ln] = hEvt;
    if (hEvt) expHostL[ln] = lvl;
    for (int c = 0; c < NC; c++) if (cEvt[c]) expCardL[ln*NC+c] = lvl;
    check(hostEvt == expH && cardEvt == expEvt, req, "events R8",
          {hostEvt, cardEvt}, {expH, expEvt});
    check(hostLevel == expHostL, req, "host level R9", 64'(hostLevel), 64'(expHostL));
    check(cardLevel == expCardL, req, "card level R9", 64'(cardLevel), 64'(expCardL));
  endtask

  task automatic checkIdle(input string req);
    @(negedge clk);
    check(hostEvt == '0 && cardEvt == '0, req, "pulse cleared",
          {hostEvt, cardEvt}, 64'd0);
  endtask

  task automatic checkReset();
    expHostL = '1;
    expCardL = '1;
    check(hostEvt == '0 && cardEvt == '0, "R1", "events at reset",
          {hostEvt, cardEvt}, 64'd0);
    check(hostLevel == '1 && cardLevel == '1, "R1", "levels at reset",
          {hostLevel, cardLevel}, {4'hF, {60{1'b1}}});
  endtask

  initial begin
    expHostL = '1;
    expCardL = '1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkReset();
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][22:21], VEC[i][20:17], VEC[i][16], VEC[i][15], VEC[i][14:0], "table");
    end
    checkIdle("R8");
    // R1: reset mid-run clears masks and levels
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkReset();
    // R3 R1: card1's old assertion is gone, so its release is no change
    apply(2'd0, 4'd1, 1'b1, 1'b0, 15'h0000, "R1 R3");
    // R5: nobody else holds line 0 now
    apply(2'd0, 4'd3, 1'b0, 1'b1, 15'h0017, "R1 R5");
    checkIdle("R8");
    // R7: empty slot 0 silences every card
    slotFilled = 15'h7FFE;
    apply(2'd1, 4'd2, 1'b0, 1'b1, 15'h0000, "R7");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 5000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule